// File: doc/BRIEF.md
# Clock Stop-Mode Power Controller

This block controls the clocks of a small microcontroller. It holds three byte-wide registers on a simple register bus: a write-lock register, a clock configuration register and a stop register. Software uses the bus to pick the oscillator that drives the system clock, to turn the main or sub oscillator gate on or off, and to put the whole chip into stop mode. In stop mode every clock gate is off.

While stopped, the block watches the interrupt request lines. Each source has an enable bit and a programmed priority level. The block leaves stop mode only if three things hold: the processor's interrupt enable flag is set, a source is both requesting and enabled, and that source's level is strictly above the processor's current level. After wake-up the oscillator gates come back at once. The processor clock stays off for a fixed settling count, which is a parameter, so that the oscillator can stabilise.

The clock configuration survives the stop, so the processor resumes on the same oscillator. Writes to the two clock registers only take effect while the lock register's unlock bit is set. Moving to the sub oscillator takes two writes: the first enables the sub-clock port, the second selects it.

Top module: `stop_clock_ctrl`

## Requirements
- R1: After reset, all three registers read 0. mainClkEn is 1, subClkEn is 0, sysClkSel is 0 (main oscillator) and cpuClkEn is 1.
- R2: A write to the clock configuration register (0x06) or the stop register (0x07) is discarded while the unlock bit is 0. The register then reads back its previous value, and no stop occurs.
- R3: The lock register is at 0x0A and its unlock bit is bit 0. This register can always be written while the processor runs. Writes to 0x06 and 0x07 take effect while the bit is 1.
- R4: Reserved bits always read 0. These are bits 7..3 of 0x06, bits 7..1 of 0x07 and bits 7..1 of 0x0A. A write that sets any reserved bit of its target register is discarded as a whole. Reads of any other address return 0.
- R5: Layout of 0x06: bit 0 = 1 turns the main oscillator gate off, bit 1 = 1 enables the sub-clock port (subClkEn), and bit 2 = 1 selects the sub oscillator as system clock (sysClkSel = 1).
- R6: Bit 2 of 0x06 becomes 1 only if bit 1 was already 1 before the write and the write also sets bit 1. A single write that sets bits 1 and 2 together from 0 enables the port but leaves sysClkSel at 0. Writing bit 1 as 0 also clears bit 2.
- R7: An accepted write of 1 to bit 0 of 0x07 enters stop mode on the next cycle. In stop mode mainClkEn, subClkEn and cpuClkEn are 0, and 0x07 reads 1.
- R8: Stop mode is left at the clock edge where all of these hold: cpuIntEn is 1, and some source i has irqReq[i] = 1, irqEnable[i] = 1 and a level strictly greater than cpuLevel. A level equal to cpuLevel, a disabled source or cpuIntEn = 0 keeps the block stopped.
- R9: On wake-up, bit 0 of 0x07 clears and the oscillator gates follow 0x06 again from the next cycle. cpuClkEn stays 0 for SETTLE_CYCLES cycles and then returns to 1.
- R10: The contents of 0x06, including the selected clock source, are the same after wake-up as before stop.
- R11: Bus writes to any register are ignored while the block is stopped or settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| irqReq | input | NUM_SRC | Interrupt request per source |
| irqEnable | input | NUM_SRC | Interrupt enable per source |
| irqLevel | input | NUM_SRC*LVL_W | Priority level per source, source i at bits i*LVL_W upward |
| cpuIntEn | input | 1 | Processor interrupt enable flag |
| cpuLevel | input | LVL_W | Processor interrupt priority level |
| mainClkEn | output | 1 | Main oscillator gate enable |
| subClkEn | output | 1 | Sub oscillator gate enable |
| sysClkSel | output | 1 | System clock source, 1 = sub oscillator |
| cpuClkEn | output | 1 | Processor clock enable |

## Verification
The hardest situation to reach is a wake-up attempt that fails on exactly one of its conditions. This needs the block already stopped, a requesting source and a processor level set so that only one condition is missing. The stimulus stops the block and then changes one input at a time: first a disabled source, then a level equal to the processor level, then the interrupt flag cleared. Only after that does it satisfy every condition. It also issues bus writes while the block is stopped and again while it settles, and the rule that a source switch needs two writes is driven with a single write that sets both bits.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

  localparam int DATA_W = 8;

  // bit positions inside the clock configuration register
  localparam int BIT_MAIN_OFF = 0;
  localparam int BIT_SUB_PORT = 1;
  localparam int BIT_SEL_SUB  = 2;
  // bit position inside the stop register
  localparam int BIT_ALL_STOP = 0;
  // bit position inside the lock register
  localparam int BIT_UNLOCK   = 0;

  // reserved-bit masks, a write touching any of these is discarded
  localparam logic [DATA_W-1:0] CFG_RSV  = 8'hF8;
  localparam logic [DATA_W-1:0] STOP_RSV = 8'hFE;
  localparam logic [DATA_W-1:0] LOCK_RSV = 8'hFE;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2
  } pwrState_t;

  // strobes from the control to the register datapath
  typedef struct packed {
    logic busOpen;   // bus writes may be accepted
    logic clrStop;   // wake-up accepted, clear stop bit
    logic oscOn;     // oscillator gates allowed
  } ctrlStrobes_t;

endpackage

// File: rtl/pwrctl_wake.sv
module pwrctl_wake
  import pwrctl_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3
) (
  input  logic [NUM_SRC-1:0]       irqReq,
  input  logic [NUM_SRC-1:0]       irqEnable,
  input  logic [NUM_SRC*LVL_W-1:0] irqLevel,
  input  logic                     cpuIntEn,
  input  logic [LVL_W-1:0]         cpuLevel,
  output logic                     wake
);

  logic [NUM_SRC-1:0] srcHit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [LVL_W-1:0] srcLvl;
    assign srcLvl    = irqLevel[i*LVL_W +: LVL_W];
    assign srcHit[i] = irqReq[i] && irqEnable[i] && (srcLvl > cpuLevel);
  end

  assign wake = cpuIntEn && (|srcHit);

endmodule

// File: rtl/pwrctl_regs.sv
module pwrctl_regs
  import pwrctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CFG_ADDR  = 'h06,
  parameter int STOP_ADDR = 'h07,
  parameter int LOCK_ADDR = 'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              stopWrite,
  output logic              unlockQ,
  output logic              mainClkEn,
  output logic              subClkEn,
  output logic              sysClkSel
);

  logic hitCfg, hitStop, hitLock;
  logic wrOpen;
  logic cfgWr, stopWr, lockWr;
  logic mainOffQ, subPortQ, selSubQ, allStopQ;
  logic selNext;

  assign hitCfg  = (busAddr == ADDR_W'(CFG_ADDR));
  assign hitStop = (busAddr == ADDR_W'(STOP_ADDR));
  assign hitLock = (busAddr == ADDR_W'(LOCK_ADDR));

  assign wrOpen  = strobes.busOpen && busWrEn;
  assign lockWr  = wrOpen && hitLock && ((busWrData & LOCK_RSV) == '0);
  assign cfgWr   = wrOpen && hitCfg && unlockQ && ((busWrData & CFG_RSV) == '0);
  assign stopWr  = wrOpen && hitStop && unlockQ && ((busWrData & STOP_RSV) == '0);

  assign stopWrite = stopWr && busWrData[BIT_ALL_STOP];

  // the source may move to the sub oscillator only when its port was
  // already enabled and stays enabled in this write
  assign selNext = busWrData[BIT_SEL_SUB] && busWrData[BIT_SUB_PORT] && subPortQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockQ  <= 1'b0;
      mainOffQ <= 1'b0;
      subPortQ <= 1'b0;
      selSubQ  <= 1'b0;
      allStopQ <= 1'b0;
    end else begin
      if (lockWr) begin
        unlockQ <= busWrData[BIT_UNLOCK];
      end
      if (cfgWr) begin
        mainOffQ <= busWrData[BIT_MAIN_OFF];
        subPortQ <= busWrData[BIT_SUB_PORT];
        selSubQ  <= selNext;
      end
      if (strobes.clrStop) begin
        allStopQ <= 1'b0;
      end else if (stopWrite) begin
        allStopQ <= 1'b1;
      end
    end
  end

  always_comb begin
    busRdData = '0;
    if (hitCfg) begin
      busRdData[BIT_MAIN_OFF] = mainOffQ;
      busRdData[BIT_SUB_PORT] = subPortQ;
      busRdData[BIT_SEL_SUB]  = selSubQ;
    end else if (hitStop) begin
      busRdData[BIT_ALL_STOP] = allStopQ;
    end else if (hitLock) begin
      busRdData[BIT_UNLOCK] = unlockQ;
    end
  end

  assign mainClkEn = strobes.oscOn && !mainOffQ;
  assign subClkEn  = strobes.oscOn && subPortQ;
  assign sysClkSel = selSubQ;

endmodule

// File: rtl/pwrctl_fsm.sv
module pwrctl_fsm
  import pwrctl_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         stopWrite,
  input  logic         wake,
  output pwrState_t    stateQ,
  output ctrlStrobes_t strobes,
  output logic         cpuClkEn
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_RUN;
      settleCnt <= '0;
    end else begin
      case (stateQ)
        ST_RUN: begin
          if (stopWrite) stateQ <= ST_STOP;
        end
        ST_STOP: begin
          if (wake) begin
            stateQ    <= ST_SETTLE;
            settleCnt <= '0;
          end
        end
        ST_SETTLE: begin
          if (settleCnt == CNT_LAST) begin
            stateQ <= ST_RUN;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        default: stateQ <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobes.busOpen = (stateQ == ST_RUN);
    strobes.clrStop = (stateQ == ST_STOP) && wake;
    strobes.oscOn   = (stateQ != ST_STOP);
  end

  assign cpuClkEn = (stateQ == ST_RUN);

endmodule

// File: rtl/stop_clock_ctrl.sv
module stop_clock_ctrl
  import pwrctl_pkg::*;
#(
  parameter int NUM_SRC       = 8,
  parameter int LVL_W         = 3,
  parameter int ADDR_W        = 8,
  parameter int SETTLE_CYCLES = 16,
  parameter int CFG_ADDR      = 'h06,
  parameter int STOP_ADDR     = 'h07,
  parameter int LOCK_ADDR     = 'h0A
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic [7:0]               busWrData,
  output logic [7:0]               busRdData,
  input  logic [NUM_SRC-1:0]       irqReq,
  input  logic [NUM_SRC-1:0]       irqEnable,
  input  logic [NUM_SRC*LVL_W-1:0] irqLevel,
  input  logic                     cpuIntEn,
  input  logic [LVL_W-1:0]         cpuLevel,
  output logic                     mainClkEn,
  output logic                     subClkEn,
  output logic                     sysClkSel,
  output logic                     cpuClkEn
);

  ctrlStrobes_t strobes;
  pwrState_t    stateQ;
  logic         stopWrite;
  logic         wake;
  logic         unlockQ;

  pwrctl_wake #(
    .NUM_SRC (NUM_SRC),
    .LVL_W   (LVL_W)
  ) uWake (
    .irqReq    (irqReq),
    .irqEnable (irqEnable),
    .irqLevel  (irqLevel),
    .cpuIntEn  (cpuIntEn),
    .cpuLevel  (cpuLevel),
    .wake      (wake)
  );

  pwrctl_fsm #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) uFsm (
    .clk       (clk),
    .rstN      (rstN),
    .stopWrite (stopWrite),
    .wake      (wake),
    .stateQ    (stateQ),
    .strobes   (strobes),
    .cpuClkEn  (cpuClkEn)
  );

  pwrctl_regs #(
    .ADDR_W    (ADDR_W),
    .CFG_ADDR  (CFG_ADDR),
    .STOP_ADDR (STOP_ADDR),
    .LOCK_ADDR (LOCK_ADDR)
  ) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .stopWrite (stopWrite),
    .unlockQ   (unlockQ),
    .mainClkEn (mainClkEn),
    .subClkEn  (subClkEn),
    .sysClkSel (sysClkSel)
  );

endmodule

// File: rtl/stop_clock_ctrl_chk.sv
module stop_clock_ctrl_chk
  import pwrctl_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int SETTLE_CYCLES = 16,
  parameter int STOP_ADDR     = 'h07
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [7:0]        busWrData,
  input logic              cpuIntEn,
  input logic              mainClkEn,
  input logic              subClkEn,
  input logic              sysClkSel,
  input logic              cpuClkEn,
  input pwrState_t         stateQ,
  input logic              unlockQ
);

  localparam int SEEN_W = $clog2(SETTLE_CYCLES + 2);

  logic [SEEN_W-1:0] settleSeen;
  logic              stopWrHit;

  assign stopWrHit = busWrEn && (busAddr == ADDR_W'(STOP_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleSeen <= '0;
    end else if (stateQ == ST_SETTLE) begin
      settleSeen <= settleSeen + 1'b1;
    end else begin
      settleSeen <= '0;
    end
  end

  // R7: stop mode gates every clock
  p_stop_gates_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_STOP) |-> (!mainClkEn && !subClkEn && !cpuClkEn));

  // R7: an accepted stop write enters stop mode
  p_enter_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && unlockQ && stopWrHit && busWrData == 8'h01) |=> (stateQ == ST_STOP));

  // R2: locked stop write has no effect
  p_locked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && !unlockQ && stopWrHit) |=> (stateQ == ST_RUN && $stable(sysClkSel)));

  // R8: no wake while the processor flag is clear
  p_no_wake_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_STOP && !cpuIntEn) |=> (stateQ == ST_STOP));

  // R9: stop never returns straight to run
  p_stop_to_settle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_STOP) |=> (stateQ != ST_RUN));

  // R9: processor clock held off while settling
  p_settle_cpu_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SETTLE) |-> !cpuClkEn);

  // R9: settling lasts no more than the programmed count
  p_settle_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SETTLE) |-> (settleSeen < SEEN_W'(SETTLE_CYCLES)));

  // R6: source switch only after the port was on
  p_sel_rose_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysClkSel) |-> $past(subClkEn));

  // R6: sub selected implies its gate is on when oscillators run
  p_sel_port_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sysClkSel && stateQ != ST_STOP) |-> subClkEn);

  // R10: clock source kept through stop and settle
  p_sel_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_RUN) |=> $stable(sysClkSel));

endmodule

bind stop_clock_ctrl stop_clock_ctrl_chk #(
  .ADDR_W        (ADDR_W),
  .SETTLE_CYCLES (SETTLE_CYCLES),
  .STOP_ADDR     (STOP_ADDR)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .cpuIntEn  (cpuIntEn),
  .mainClkEn (mainClkEn),
  .subClkEn  (subClkEn),
  .sysClkSel (sysClkSel),
  .cpuClkEn  (cpuClkEn),
  .stateQ    (stateQ),
  .unlockQ   (unlockQ)
);

// File: tb/tb_stop_clock_ctrl.sv
`timescale 1ns/1ps
module tb_stop_clock_ctrl;

  localparam int NSRC   = 8;
  localparam int LW     = 3;
  localparam int AW     = 8;
  localparam int SETTLE = 6;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [AW-1:0]      busAddr = '0;
  logic               busWrEn = 1'b0;
  logic [7:0]         busWrData = '0;
  logic [7:0]         busRdData;
  logic [NSRC-1:0]    irqReq = '0;
  logic [NSRC-1:0]    irqEnable = '0;
  logic [NSRC*LW-1:0] irqLevel = '0;
  logic               cpuIntEn = 1'b0;
  logic [LW-1:0]      cpuLevel = '0;
  logic               mainClkEn, subClkEn, sysClkSel, cpuClkEn;

  always #2 clk = ~clk;

  stop_clock_ctrl #(
    .NUM_SRC (NSRC), .LVL_W (LW), .ADDR_W (AW), .SETTLE_CYCLES (SETTLE)
  ) dut (
    .clk (clk), .rstN (rstN), .busAddr (busAddr), .busWrEn (busWrEn),
    .busWrData (busWrData), .busRdData (busRdData), .irqReq (irqReq),
    .irqEnable (irqEnable), .irqLevel (irqLevel), .cpuIntEn (cpuIntEn),
    .cpuLevel (cpuLevel), .mainClkEn (mainClkEn), .subClkEn (subClkEn),
    .sysClkSel (sysClkSel), .cpuClkEn (cpuClkEn)
  );

  // behavioural reference: 0 run, 1 stopped, 2 settling
  int mUnlock, mMainOff, mSubPort, mSel, mStop, mState, mCnt;
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  string phaseReq = "R1";

  function automatic int wakeNow();
    int hit = 0;
    for (int i = 0; i < NSRC; i++)
      if (irqReq[i] && irqEnable[i] && (int'(irqLevel[i*LW +: LW]) > int'(cpuLevel))) hit = 1;
    return (cpuIntEn && hit) ? 1 : 0;
  endfunction

  task automatic modelStep();
    int d = busWrData;
    int a = busAddr;
    if (!rstN) begin
      mUnlock = 0; mMainOff = 0; mSubPort = 0; mSel = 0; mStop = 0; mState = 0; mCnt = 0;
      return;
    end
    case (mState)
      0: if (busWrEn) begin
        if (a == 'h0A && (d & 'hFE) == 0) mUnlock = d & 1;
        else if (a == 'h06 && mUnlock == 1 && (d & 'hF8) == 0) begin
          mSel     = ((d & 4) != 0 && (d & 2) != 0 && mSubPort == 1) ? 1 : 0;
          mSubPort = (d >> 1) & 1;
          mMainOff = d & 1;
        end else if (a == 'h07 && mUnlock == 1 && d == 1) begin
          mStop = 1; mState = 1;
        end
      end
      1: if (wakeNow() == 1) begin mStop = 0; mState = 2; mCnt = 0; end
      default: if (mCnt == SETTLE - 1) mState = 0; else mCnt++;
    endcase
  endtask

  function automatic int expRead();
    int a = busAddr;
    if (a == 'h06) return mMainOff | (mSubPort << 1) | (mSel << 2);
    if (a == 'h07) return mStop;
    if (a == 'h0A) return mUnlock;
    return 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(phaseReq, "mainClkEn", mainClkEn, (mState != 1 && mMainOff == 0) ? 1 : 0);
    chk(phaseReq, "subClkEn", subClkEn, (mState != 1 && mSubPort == 1) ? 1 : 0);
    chk(phaseReq, "sysClkSel", sysClkSel, mSel);
    chk(phaseReq, "cpuClkEn", cpuClkEn, (mState == 0) ? 1 : 0);
    chk(phaseReq, "busRdData", busRdData, expRead());
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic wr(int a, int d);
    busAddr = AW'(a); busWrData = 8'(d); busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0;
    tick();
  endtask

  task automatic rd(int a);
    busAddr = AW'(a);
    tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    modelStep();
    @(negedge clk);
    // R1: reset values
    phaseReq = "R1";
    idle(3);
    rstN = 1'b1;
    rd('h06); rd('h07); rd('h0A); rd('h33);

    // R2: locked writes dropped
    phaseReq = "R2";
    wr('h06, 'h03); rd('h06);
    wr('h07, 'h01); idle(2);

    // R3: unlock then program
    phaseReq = "R3";
    wr('h0A, 'h01); rd('h0A);
    wr('h06, 'h02); rd('h06);

    // R4: reserved bits
    phaseReq = "R4";
    wr('h0A, 'hFF); rd('h0A);
    wr('h06, 'hFA); rd('h06);
    wr('h07, 'hFF); idle(2);
    wr('h07, 'h03); idle(2);

    // R5: main oscillator off and back
    phaseReq = "R5";
    wr('h06, 'h01); wr('h06, 'h00);

    // R6: two-step source switch
    phaseReq = "R6";
    wr('h06, 'h06); rd('h06);
    wr('h06, 'h06); rd('h06);
    wr('h06, 'h04); rd('h06);
    wr('h06, 'h02); wr('h06, 'h07); rd('h06);

    // R2: relock, then a locked write must not change the sub selection
    phaseReq = "R2";
    wr('h0A, 'h00); wr('h06, 'h00); rd('h06);
    wr('h0A, 'h01);

    // R7: enter stop
    phaseReq = "R7";
    irqLevel = '0;
    irqLevel[2*LW +: LW] = 3'd3;
    irqLevel[7*LW +: LW] = 3'd7;
    cpuLevel = 3'd3;
    wr('h07, 'h01); rd('h07); idle(3);

    // R11: writes while stopped
    phaseReq = "R11";
    wr('h06, 'h00); wr('h0A, 'h00); rd('h06); rd('h0A);

    // R8: each wake condition missing in turn
    phaseReq = "R8";
    irqReq[2] = 1'b1; cpuIntEn = 1'b1; idle(3);
    irqEnable[2] = 1'b1; idle(3);
    cpuLevel = 3'd2; cpuIntEn = 1'b0; idle(3);
    phaseReq = "R9";
    cpuIntEn = 1'b1; tick();
    irqReq = '0;
    // R11: writes while settling
    phaseReq = "R11";
    busAddr = AW'('h06); busWrData = 8'h00; busWrEn = 1'b1; tick(); busWrEn = 1'b0;
    phaseReq = "R9";
    idle(SETTLE + 2);

    // R10: configuration kept
    phaseReq = "R10";
    rd('h06); rd('h07); rd('h0A);

    // R8: second stop woken by a different source
    phaseReq = "R8";
    wr('h06, 'h02);
    cpuLevel = 3'd6;
    wr('h07, 'h01); idle(2);
    irqEnable[7] = 1'b1; idle(2);
    irqReq[7] = 1'b1; tick();
    irqReq = '0;
    phaseReq = "R9";
    idle(SETTLE + 2);
    phaseReq = "R10";
    rd('h06);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule